// File: doc/BRIEF.md
# Reloading Down-Counting Interval Timer

A 16-bit interval timer that counts down once for each cycle on which an external timebase strobe is high and the timer is enabled. Software reaches three byte-wide registers through a plain byte bus: a control/status register, a modulus register it can read and write, and a count register it can only read. When the count arrives at zero, the block sets a sticky flag. An interrupt line follows that flag whenever interrupts are enabled.

Two modes are available. In reload mode, the tick after the zero state loads the modulus value, which gives a periodic event with no further software action. In free-run mode, the counter wraps to 0xFFFF instead. The count is read as two separate byte accesses. No latch holds one half while the other is read, so a tick that falls between the two reads gives a pair of halves from different count values. Writes to the count register are accepted and have no effect. If the modulus is written while the timer is disabled, the counter takes the new full modulus value, so a known start value is in place before the timer is enabled.

The register port carries no stream data, so it stays a plain strobe bus with no valid/ready handshake and no back-pressure. A write completes in the cycle it is strobed. Read data is combinational from the address.

Top module: `interval_timer_top`

## Requirements
- R1: After reset, the modulus and count registers both read 0xFFFF, both control bytes read 0x00, and `irq_o` is low.
- R2: The modulus register is read/write, with its high byte at offset 2 and its low byte at offset 3.
- R3: The count is read with its high byte at offset 4 and its low byte at offset 5. Writes to either offset leave the count unchanged.
- R4: A write to either modulus byte while the enable bit is 0 loads the complete new 16-bit modulus value into the counter.
- R5: The count decrements by one only on a cycle where the enable bit and `tick_en` are both 1. On any other cycle it holds.
- R6: A tick that moves the count to 0x0000 sets the flag.
- R7: When the reload bit is 1, the tick after the count is 0x0000 loads the modulus value.
- R8: When the reload bit is 0, the tick after the count is 0x0000 loads 0xFFFF.
- R9: `irq_o` is high exactly while the flag and the interrupt-enable bit are both 1.
- R10: Writing 1 to the flag bit clears the flag, and writing 0 to it has no effect. A set caused by the counter in the same cycle as a clear wins.
- R11: The control byte at offset 1 holds bit 0 = enable, bit 1 = reload, bit 2 = flag and bit 3 = interrupt enable. Offset 0 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timebase strobe; one count step per high cycle |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 3 | Byte offset within the register window |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The counting function is driven with three kinds of tick pattern. Runs of ticks with the timer enabled tell a correct step of one apart from a stalled or skipped step. Ticks across zero with the reload bit set and then clear tell modulus reload apart from wrap-around. Ticks with the timer disabled show that the enable gate is honoured. The modulus is loaded one byte at a time, which separates a full-value load from a single-lane load. A clear written in the same cycle as a zero-reaching tick shows whether set or clear has priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 3;
  // byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTL_HI = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTL_LO = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_MOD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_MOD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 3'd5;
  // control bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_RLD  = 1;
  localparam int unsigned BIT_FLAG = 2;
  localparam int unsigned BIT_IE   = 3;

  typedef struct packed {
    logic ie;
    logic flag;
    logic rld;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tmr_modulus.sv
module tmr_modulus #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W/8-1:0] lane_wr,
  input  logic [7:0]   wdata,
  output logic [W-1:0] mod_q,
  output logic [W-1:0] mod_d
);
  localparam int unsigned NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign mod_d[b*8 +: 8] = lane_wr[b] ? wdata : mod_q[b*8 +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mod_q[b*8 +: 8] <= 8'hFF;
      else        mod_q[b*8 +: 8] <= mod_d[b*8 +: 8];
    end
  end

  p_mod_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr == '0) |=> $stable(mod_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         reload_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] mod_q,
  output logic [W-1:0] cnt_q,
  output logic         zero_evt
);
  localparam logic [W-1:0] ALL_ONES = '1;
  logic [W-1:0] step_val;
  logic         at_zero;

  assign at_zero  = (cnt_q == '0);
  assign step_val = at_zero ? (reload_en ? mod_q : ALL_ONES) : cnt_q - 1'b1;
  assign zero_evt = adv && (step_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= ALL_ONES;
    else if (load) cnt_q <= load_val;
    else if (adv)  cnt_q <= step_val;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(cnt_q));
  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && at_zero && reload_en) |=> (cnt_q == $past(mod_q)));
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && at_zero && !reload_en) |=> (cnt_q == ALL_ONES));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic [7:0] wdata,
  input  logic       set_flag,
  output ctl_t       ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.en  <= wdata[BIT_EN];
        ctl_q.rld <= wdata[BIT_RLD];
        ctl_q.ie  <= wdata[BIT_IE];
      end
      if (set_flag)                      ctl_q.flag <= 1'b1;
      else if (wr_ctl && wdata[BIT_FLAG]) ctl_q.flag <= 1'b0;
    end
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> ctl_q.flag);
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.flag && !(wr_ctl && wdata[BIT_FLAG])) |=> ctl_q.flag);
  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[BIT_FLAG] && !set_flag) |=> !ctl_q.flag);
endmodule

// File: rtl/interval_timer_top.sv
module interval_timer_top
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_o
);
  localparam int unsigned NB = CNT_W / 8;

  ctl_t             ctl_q;
  logic [CNT_W-1:0] mod_q, mod_d, cnt_q;
  logic [NB-1:0]    lane_wr;
  logic             zero_evt, adv, mod_load, wr_ctl;

  assign wr_ctl     = reg_wr && (reg_addr == OFS_CTL_LO);
  assign lane_wr[1] = reg_wr && (reg_addr == OFS_MOD_HI);
  assign lane_wr[0] = reg_wr && (reg_addr == OFS_MOD_LO);
  assign mod_load   = (|lane_wr) && !ctl_q.en;
  assign adv        = ctl_q.en && tick_en;

  tmr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(reg_wdata),
    .set_flag(zero_evt), .ctl_q(ctl_q)
  );

  tmr_modulus #(.W(CNT_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .lane_wr(lane_wr), .wdata(reg_wdata),
    .mod_q(mod_q), .mod_d(mod_d)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .reload_en(ctl_q.rld),
    .load(mod_load), .load_val(mod_d), .mod_q(mod_q),
    .cnt_q(cnt_q), .zero_evt(zero_evt)
  );

  always_comb begin
    unique case (reg_addr)
      OFS_CTL_LO: reg_rdata = {4'h0, ctl_q};
      OFS_MOD_HI: reg_rdata = mod_q[15:8];
      OFS_MOD_LO: reg_rdata = mod_q[7:0];
      OFS_CNT_HI: reg_rdata = cnt_q[15:8];
      OFS_CNT_LO: reg_rdata = cnt_q[7:0];
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign irq_o = ctl_q.flag && ctl_q.ie;

  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && ctl_q.ie && !wr_ctl) |=> irq_o);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.ie && !wr_ctl) |=> !irq_o);
  p_cnt_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == OFS_CNT_LO || reg_addr == OFS_CNT_HI) && !tick_en)
      |=> $stable(cnt_q));
endmodule

// File: tb/interval_timer_top_tb_top.sv
module interval_timer_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o;
  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  interval_timer_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  // vector: {op[1:0], addr[2:0], data[7:0]}; op 0=write 1=read-check 2=ticks
  localparam int NV = 41;
  localparam logic [12:0] VEC [NV] = '{
    {2'd1,3'd4,8'hFF}, {2'd1,3'd5,8'hFF}, {2'd1,3'd2,8'hFF}, {2'd1,3'd3,8'hFF}, // R1
    {2'd1,3'd1,8'h00}, {2'd1,3'd0,8'h00},                                      // R1 R11
    {2'd0,3'd2,8'h00}, {2'd1,3'd4,8'h00}, {2'd1,3'd5,8'hFF},                   // R4
    {2'd0,3'd3,8'h03}, {2'd1,3'd5,8'h03}, {2'd1,3'd2,8'h00}, {2'd1,3'd3,8'h03}, // R2 R4
    {2'd0,3'd1,8'h0B}, {2'd2,3'd0,8'd2},  {2'd1,3'd5,8'h01},                   // R5
    {2'd2,3'd0,8'd1},  {2'd1,3'd5,8'h00}, {2'd1,3'd1,8'h0F},                   // R6
    {2'd2,3'd0,8'd1},  {2'd1,3'd5,8'h03}, {2'd1,3'd4,8'h00}, {2'd1,3'd1,8'h0F}, // R7
    {2'd0,3'd1,8'h0F}, {2'd1,3'd1,8'h0B},                                      // R10
    {2'd0,3'd5,8'h55}, {2'd0,3'd4,8'hAA}, {2'd1,3'd5,8'h03}, {2'd1,3'd4,8'h00}, // R3
    {2'd0,3'd1,8'h09}, {2'd2,3'd0,8'd3},  {2'd1,3'd5,8'h00},
    {2'd2,3'd0,8'd1},  {2'd1,3'd4,8'hFF}, {2'd1,3'd5,8'hFF}, {2'd1,3'd1,8'h0D}, // R8
    {2'd0,3'd1,8'h00}, {2'd2,3'd0,8'd2},  {2'd1,3'd5,8'hFF},                   // R5 hold
    {2'd0,3'd3,8'h10}, {2'd1,3'd5,8'h10}                                       // R4
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] e);
    reg_addr = a; #1;
    chk(req, reg_rdata, e);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][12:11])
        2'd0: wr(VEC[i][10:8], VEC[i][7:0]);
        2'd1: rd($sformatf("vector %0d (R1..R11)", i), VEC[i][10:8], VEC[i][7:0]);
        default: ticks(int'(VEC[i][7:0]));
      endcase
    end
    // flag still set but interrupts disabled: R9
    chk("R9 irq gated", {7'd0, irq_o}, 8'h00);
    rd("R10 flag kept on write 0", 3'd1, 8'h04);
    wr(3'd1, 8'h04);
    rd("R10 flag cleared", 3'd1, 8'h00);
    // write to offset 0 ignored: R11
    wr(3'd0, 8'hFF);
    rd("R11 offset 0", 3'd0, 8'h00);
    rd("R11 ctl unaffected", 3'd1, 8'h00);
    // set-vs-clear priority: R10
    wr(3'd3, 8'h01);
    wr(3'd2, 8'h00);
    rd("R4 load one", 3'd5, 8'h01);
    wr(3'd1, 8'h0B);
    @(negedge clk);
    tick_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h0F;
    @(negedge clk);
    tick_en = 1'b0; reg_wr = 1'b0;
    rd("R10 set wins", 3'd1, 8'h0F);
    rd("R6 count zero", 3'd5, 8'h00);
    chk("R9 irq high", {7'd0, irq_o}, 8'h01);
    wr(3'd1, 8'h03);
    chk("R9 irq off with ie=0", {7'd0, irq_o}, 8'h00);
    rd("R11 ctl readback", 3'd1, 8'h07);
    finish_up();
  end
endmodule